// File: doc/BRIEF.md
# Vertical-Blank NMI Flag Controller

This block keeps the vertical-blank interrupt flag of a video timing system and tells the processor-side interrupt logic when to take a non-maskable interrupt. It watches the same quarter-rate tick and line-phase count as the raster timer. It also watches the current scanline number and a programmable scanline number on which vertical blank begins. The flag is raised early on that line and dropped early on line 0. On the blanking line, when interrupts are enabled, a request strobe goes out that carries a short delay code for the processor side.

Software uses two plain ports. The first is a control write that holds the interrupt enable and two raster-match enables. The enables for vertical and horizontal matching go to the neighbouring raster timer. The second is a status read that returns the flag with a fixed revision code and clears the flag as a side effect. A guard window just after the flag rises keeps a read from wiping out a flag that was only just set. If software turns the enable on while the flag is already up, a request goes out at once with a longer delay code. All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `vblank_nmi_ctl`

## Requirements
- R1: When `tick` is high, `phase` equals 2 and `line` equals `nmi_line`, the flag is set. With `tick` low, the same phase and line have no effect.
- R2: When `tick` is high, `phase` equals 2 and `line` equals 0 (and 0 is not the blanking line), the flag is cleared.
- R3: `stat_rdata` bit 7 is the flag as seen in the current cycle, including a set that happens in that same cycle. Bits 6:0 carry the `REVISION` parameter.
- R4: A status read (`stat_re` high) clears the flag at the next edge in two cases: `phase` is 6 or more, or `line` differs from `nmi_line`. On the blanking line with `phase` below 6, a read leaves the flag set.
- R5: A read in the same cycle as the set event returns bit 7 as 1 and leaves the flag set.
- R6: A control write stores the enables from three bits of `ctl_wdata`. Bit 7 is the interrupt enable (`nmi_enable`). Bit 5 is vertical matching (`vmatch_en`). Bit 4 is horizontal matching (`hmatch_en`). After the edge, all three outputs show the written bits.
- R7: When `tick` is high, `phase` equals 6, `line` equals `nmi_line` and `nmi_enable` is 1, `nmi_req` pulses in the next cycle with `nmi_delay` = 1. When the enable is 0, that cycle gives no request.
- R8: A control write that takes `nmi_enable` from 0 to 1 while bit 7 of the status is 1 pulses `nmi_req` in the next cycle with `nmi_delay` = 2. No request follows if the flag is 0 or if the enable was already 1.
- R9: `nmi_req` is high only for cycles that follow an R7 or R8 event. `nmi_delay` is 0 whenever `nmi_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Quarter-rate timing tick qualifier |
| phase | input | PW | Position within the current line |
| line | input | LW | Current scanline number |
| nmi_line | input | LW | Scanline on which vertical blank begins |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| stat_re | input | 1 | Status read strobe (clears flag) |
| stat_rdata | output | 8 | Status value: flag in bit 7, revision in 6:0 |
| nmi_enable | output | 1 | Stored interrupt enable |
| vmatch_en | output | 1 | Stored vertical-match enable |
| hmatch_en | output | 1 | Stored horizontal-match enable |
| nmi_req | output | 1 | One-cycle interrupt request strobe |
| nmi_delay | output | 2 | Delay code carried with the request |

## Verification
A flag register stuck set or stuck clear shows on bit 7 of the very next status read. A guard window that is too wide or too narrow shows as a read that clears too early or too late. That difference appears as soon as two reads sit on either side of phase 6. A wrong enable-edge detector or request register shows up one cycle after the trigger, in one of three ways: a missing pulse, an extra pulse, or the wrong delay code. A scoreboard of expected delay codes catches each case at the pulse itself.

// File: rtl/vnc_pkg.sv
package vnc_pkg;
  localparam int CTL_W           = 8;
  localparam int BIT_NMI_EN      = 7;
  localparam int BIT_VMATCH      = 5;
  localparam int BIT_HMATCH      = 4;
  localparam int PHASE_SET       = 2;
  localparam int PHASE_FIRE      = 6;
  localparam int PHASE_GUARD_END = 6;

  typedef enum logic [1:0] {
    DLY_NONE = 2'd0,
    DLY_ONE  = 2'd1,
    DLY_TWO  = 2'd2
  } nmi_dly_e;

  typedef struct packed {
    logic nmi_en;
    logic v_en;
    logic h_en;
  } ctl_t;
endpackage

// File: rtl/vnc_phase_decode.sv
module vnc_phase_decode
  import vnc_pkg::*;
#(
  parameter int PW = 11,
  parameter int LW = 9
) (
  input  logic          tick,
  input  logic [PW-1:0] phase,
  input  logic [LW-1:0] line,
  input  logic [LW-1:0] nmi_line,
  output logic          set_ev,
  output logic          clr_ev,
  output logic          fire_ev,
  output logic          in_guard
);
  localparam logic [PW-1:0] PH_SET   = PW'(PHASE_SET);
  localparam logic [PW-1:0] PH_FIRE  = PW'(PHASE_FIRE);
  localparam logic [PW-1:0] PH_GUARD = PW'(PHASE_GUARD_END);

  logic on_nmi_line;
  logic on_line0;
  logic at_set;
  logic at_fire;

  always_comb begin
    on_nmi_line = (line == nmi_line);
    on_line0    = (line == '0);
    at_set      = (phase == PH_SET);
    at_fire     = (phase == PH_FIRE);
    set_ev      = tick & at_set & on_nmi_line;
    clr_ev      = tick & at_set & on_line0 & ~on_nmi_line;
    fire_ev     = tick & at_fire & on_nmi_line;
    in_guard    = on_nmi_line & (phase < PH_GUARD);
  end
endmodule

// File: rtl/vnc_ctrl_reg.sv
module vnc_ctrl_reg
  import vnc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl,
  output logic             en_rise
);
  ctl_t ctl_q;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[6], wdata[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q.nmi_en <= wdata[BIT_NMI_EN];
      ctl_q.v_en   <= wdata[BIT_VMATCH];
      ctl_q.h_en   <= wdata[BIT_HMATCH];
    end
  end

  assign ctl     = ctl_q;
  assign en_rise = we & wdata[BIT_NMI_EN] & ~ctl_q.nmi_en;
endmodule

// File: rtl/vnc_flag_core.sv
module vnc_flag_core (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic rd_en,
  input  logic in_guard,
  output logic flag_view
);
  logic flag_q;
  logic rd_clear;

  assign rd_clear  = rd_en & flag_q & ~in_guard;
  assign flag_view = flag_q | set_ev;

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (set_ev)   flag_q <= 1'b1;
    else if (clr_ev)   flag_q <= 1'b0;
    else if (rd_clear) flag_q <= 1'b0;
  end
endmodule

// File: rtl/vnc_req_gen.sv
module vnc_req_gen
  import vnc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire_ev,
  input  logic     nmi_en,
  input  logic     en_rise,
  input  logic     flag_view,
  output logic     req,
  output nmi_dly_e dly
);
  logic fire_line;
  logic fire_late;

  assign fire_line = fire_ev & nmi_en;
  assign fire_late = en_rise & flag_view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
      dly <= DLY_NONE;
    end else begin
      req <= fire_line | fire_late;
      if (fire_line)      dly <= DLY_ONE;
      else if (fire_late) dly <= DLY_TWO;
      else                dly <= DLY_NONE;
    end
  end
endmodule

// File: rtl/vblank_nmi_ctl.sv
module vblank_nmi_ctl
  import vnc_pkg::*;
#(
  parameter int         PW       = 11,
  parameter int         LW       = 9,
  parameter logic [6:0] REVISION = 7'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PW-1:0]    phase,
  input  logic [LW-1:0]    line,
  input  logic [LW-1:0]    nmi_line,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             stat_re,
  output logic [CTL_W-1:0] stat_rdata,
  output logic             nmi_enable,
  output logic             vmatch_en,
  output logic             hmatch_en,
  output logic             nmi_req,
  output logic [1:0]       nmi_delay
);
  logic     set_ev, clr_ev, fire_ev, in_guard;
  logic     en_rise, flag_view;
  ctl_t     ctl;
  nmi_dly_e dly;

  vnc_phase_decode #(.PW(PW), .LW(LW)) u_dec (
    .tick(tick), .phase(phase), .line(line), .nmi_line(nmi_line),
    .set_ev(set_ev), .clr_ev(clr_ev), .fire_ev(fire_ev), .in_guard(in_guard)
  );

  vnc_ctrl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl(ctl), .en_rise(en_rise)
  );

  vnc_flag_core u_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
    .rd_en(stat_re), .in_guard(in_guard), .flag_view(flag_view)
  );

  vnc_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .fire_ev(fire_ev), .nmi_en(ctl.nmi_en),
    .en_rise(en_rise), .flag_view(flag_view), .req(nmi_req), .dly(dly)
  );

  assign stat_rdata = {flag_view, REVISION};
  assign nmi_enable = ctl.nmi_en;
  assign vmatch_en  = ctl.v_en;
  assign hmatch_en  = ctl.h_en;
  assign nmi_delay  = dly;
endmodule

// File: rtl/vnc_checker.sv
module vnc_checker #(
  parameter int PW = 11,
  parameter int LW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [PW-1:0] phase,
  input logic [LW-1:0] line,
  input logic [LW-1:0] nmi_line,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic          stat_re,
  input logic [7:0]    stat_rdata,
  input logic          nmi_enable,
  input logic          nmi_req,
  input logic [1:0]    nmi_delay
);
  logic set_now, fire_now, zero_now;
  assign set_now  = tick && phase == PW'(2) && line == nmi_line;
  assign fire_now = tick && phase == PW'(6) && line == nmi_line;
  assign zero_now = tick && phase == PW'(2) && line == '0;

  a_r1_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> stat_rdata[7]);

  a_r2_line0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_now && nmi_line != '0) |=> (!stat_rdata[7] || set_now));

  a_r4_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_re && stat_rdata[7] && line == nmi_line && phase < PW'(6) && !zero_now)
    |=> stat_rdata[7]);

  a_r6_enable_store: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> nmi_enable == $past(ctl_wdata[7]));

  a_r7_line_request: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_now && nmi_enable) |=> (nmi_req && nmi_delay == 2'd1));

  a_r8_late_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7] && !nmi_enable && stat_rdata[7]) |=> (nmi_req && nmi_delay == 2'd2));

  a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && nmi_enable && !fire_now) |=> !nmi_req);

  a_r9_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_req |-> nmi_delay == 2'd0);
endmodule

bind vblank_nmi_ctl vnc_checker #(.PW(PW), .LW(LW)) u_vnc_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase), .line(line),
  .nmi_line(nmi_line), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .stat_re(stat_re), .stat_rdata(stat_rdata), .nmi_enable(nmi_enable),
  .nmi_req(nmi_req), .nmi_delay(nmi_delay)
);

// File: tb/test_vblank_nmi_ctl.sv
module test_vblank_nmi_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [10:0] phase = '0;
  logic [8:0]  line = '0;
  logic [8:0]  nmi_line = 9'd225;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        stat_re = 1'b0;
  logic [7:0]  stat_rdata;
  logic        nmi_enable, vmatch_en, hmatch_en, nmi_req;
  logic [1:0]  nmi_delay;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd_last;
  logic [1:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  vblank_nmi_ctl i_vblank_nmi_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase), .line(line),
    .nmi_line(nmi_line), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .stat_re(stat_re), .stat_rdata(stat_rdata), .nmi_enable(nmi_enable),
    .vmatch_en(vmatch_en), .hmatch_en(hmatch_en), .nmi_req(nmi_req),
    .nmi_delay(nmi_delay)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one cycle of stimulus; push > 0 queues an expected request delay code
  task automatic cyc(input logic t, input logic [10:0] ph, input logic [8:0] ln,
                     input logic re, input logic we, input logic [7:0] wd, input int push);
    @(negedge clk);
    tick = t; phase = ph; line = ln; stat_re = re; ctl_we = we; ctl_wdata = wd;
    if (push > 0) exp_q.push_back(2'(push));
    #1 rd_last = stat_rdata;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 11'd100, 9'd100, 0, 0, 8'h00, 0);
  endtask

  // monitor: compare each request pulse with the scoreboard
  always @(negedge clk) begin
    if (rst_n && nmi_req) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected request actual=1 expected=0");
      end else begin
        check("R7/R8 request delay", 32'(nmi_delay), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset status", 32'(stat_rdata), 32'h02);
    check("R6 reset enable", 32'(nmi_enable), 0);
    check("R9 reset request", 32'(nmi_req), 0);

    // R6 control bits
    cyc(0, 0, 9'd10, 0, 1, 8'hB0, 0);
    check("R6 enables set", 32'({nmi_enable, vmatch_en, hmatch_en}), 32'b111);
    check("R8 no request with flag clear", 32'(nmi_req), 0);
    cyc(0, 0, 9'd10, 0, 1, 8'h00, 0);
    check("R6 enables cleared", 32'({nmi_enable, vmatch_en, hmatch_en}), 0);
    cyc(0, 0, 9'd10, 0, 1, 8'h10, 0);
    check("R6 horizontal only", 32'({nmi_enable, vmatch_en, hmatch_en}), 32'b001);
    cyc(0, 0, 9'd10, 0, 1, 8'h00, 0);

    // R1 tick qualifier
    cyc(0, 11'd2, 9'd225, 0, 0, 8'h00, 0);
    cyc(0, 11'd0, 9'd225, 1, 0, 8'h00, 0);
    check("R1 no set without tick", 32'(rd_last[7]), 0);

    // R1 set, R3 format, R4 guard
    cyc(1, 11'd2, 9'd225, 0, 0, 8'h00, 0);
    cyc(0, 11'd3, 9'd225, 1, 0, 8'h00, 0);
    check("R1 R3 status after set", 32'(rd_last), 32'h82);
    cyc(0, 11'd5, 9'd225, 1, 0, 8'h00, 0);
    check("R4 guard keeps flag", 32'(rd_last[7]), 1);
    cyc(1, 11'd6, 9'd225, 0, 0, 8'h00, 0);
    check("R7 no request when disabled", 32'(nmi_req), 0);
    cyc(0, 11'd6, 9'd225, 1, 0, 8'h00, 0);
    check("R4 read at phase 6 returns set", 32'(rd_last[7]), 1);
    cyc(0, 11'd7, 9'd225, 1, 0, 8'h00, 0);
    check("R4 cleared by phase 6 read", 32'(rd_last[7]), 0);

    // R5 same-cycle read and set
    cyc(1, 11'd2, 9'd225, 1, 0, 8'h00, 0);
    check("R5 same-cycle read returns 1", 32'(rd_last[7]), 1);
    cyc(0, 11'd4, 9'd225, 1, 0, 8'h00, 0);
    check("R5 flag kept", 32'(rd_last[7]), 1);

    // R4 read on another line clears at low phase
    cyc(0, 11'd0, 9'd230, 1, 0, 8'h00, 0);
    check("R4 other-line read returns set", 32'(rd_last[7]), 1);
    cyc(0, 11'd0, 9'd230, 1, 0, 8'h00, 0);
    check("R4 other-line read cleared", 32'(rd_last[7]), 0);

    // R2 line 0 clear, needs tick
    cyc(1, 11'd2, 9'd225, 0, 0, 8'h00, 0);
    cyc(0, 11'd2, 9'd0, 0, 0, 8'h00, 0);
    cyc(0, 11'd3, 9'd225, 1, 0, 8'h00, 0);
    check("R2 no clear without tick", 32'(rd_last[7]), 1);
    cyc(1, 11'd2, 9'd0, 0, 0, 8'h00, 0);
    cyc(0, 11'd3, 9'd225, 1, 0, 8'h00, 0);
    check("R2 cleared at line 0", 32'(rd_last[7]), 0);

    // R8 enable with flag clear: no request
    cyc(0, 0, 9'd10, 0, 1, 8'h80, 0);
    check("R8 no request, flag clear", 32'(nmi_req), 0);

    // R7 request on blanking line
    cyc(1, 11'd2, 9'd225, 0, 0, 8'h00, 0);
    cyc(1, 11'd6, 9'd224, 0, 0, 8'h00, 0);
    check("R7 no request off line", 32'(nmi_req), 0);
    cyc(1, 11'd6, 9'd225, 0, 0, 8'h00, 1);
    check("R7 request pulse", 32'({nmi_req, nmi_delay}), 32'b101);
    idle();
    check("R9 pulse ends, code zero", 32'({nmi_req, nmi_delay}), 0);

    // R8 enable rising while flag set
    cyc(0, 0, 9'd10, 0, 1, 8'h00, 0);
    cyc(0, 0, 9'd10, 0, 1, 8'h80, 2);
    check("R8 late request", 32'({nmi_req, nmi_delay}), 32'b110);
    cyc(0, 0, 9'd10, 0, 1, 8'h80, 0);
    check("R8 no request when already enabled", 32'(nmi_req), 0);

    repeat (4) idle();
    check("R9 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule